// File: doc/BRIEF.md
# Level-2 Interrupt Aggregator

This block gathers up to 32 peripheral interrupt lines into a single request toward a parent interrupt controller. Each line passes through a synchronizer and an edge detector. A rising edge latches a sticky pending bit, and the bit stays set until software acknowledges it. A per-source disable bit decides whether a pending bit takes part in the parent request. The parent line is a registered OR of every pending bit whose source is enabled.

Software uses a plain 32-bit register bus made of a write strobe, a byte address, write data and combinational read data. The pending and disable vectors are never written directly. Each has one address where writing ones sets bits and another where writing ones clears bits, plus a read-only view. A wake output follows the same enabled-pending condition, but only while a sleep indication is high.

The block has two resets. A power-on reset clears all state. A warm reset disables every source and drops both outputs, but leaves the pending bits in place so that software can find out which source woke the system.

Top module: `irq_aggregator`

## Requirements
- R1: After power-on reset the pending vector reads 0x00000000 at byte address 0x00, the disable vector reads 0xFFFFFFFF at 0x0C, and irqOut is 0.
- R2: A rising edge on srcIn[i] sets pending bit i two clock edges after the edge that first samples it, and the bit stays set after the input returns low.
- R3: Writing data to address 0x08 clears each pending bit whose data bit is 1. Data bits that are 0 leave their pending bits unchanged.
- R4: Writing data to address 0x04 sets each pending bit whose data bit is 1.
- R5: Writing data to address 0x10 sets the matching disable bits (a 1 means the source is disabled), and writing to 0x14 clears them. Data bits that are 0 change nothing.
- R6: irqOut is registered. It equals the OR of (pending AND NOT disable) as those vectors stood before the previous clock edge.
- R7: When a rising edge reaches a pending bit in the same cycle that a clear write targets that bit, the bit stays set.
- R8: While warmRstN is low, the disable vector becomes all ones and irqOut and wakeOut go to 0. The pending vector keeps its value across the warm reset.
- R9: wakeOut is registered. It is 1 one edge after sleepMode is high and at least one enabled pending bit exists. It is 0 whenever sleepMode was low at the previous edge.
- R10: Reading any address other than 0x00 and 0x0C returns 0. Writes to 0x00 and 0x0C change no state.
- R11: An input that is held high creates only one event, so a pending bit cleared while its input stays high remains clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Synchronous active-low power-on reset; clears all state |
| warmRstN | input | 1 | Synchronous active-low warm reset; keeps pending bits |
| srcIn | input | 32 | Asynchronous peripheral interrupt lines |
| busWe | input | 1 | Register write strobe |
| busAddr | input | 8 | Register byte address |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Combinational read data for busAddr |
| sleepMode | input | 1 | System suspended; enables the wake output |
| irqOut | output | 1 | Request to the parent controller |
| wakeOut | output | 1 | Wake request while suspended |

## Verification
Register writes take effect at the edge that samples them and are visible on the read port right after it. irqOut and wakeOut follow one edge after that. Source events need three edges before they show as pending, and four before they reach irqOut.

A reference model in the bench shifts the input samples through a history of its own. It updates pending, disable and both outputs at each rising edge. Outputs are compared at the falling edge that follows. Explicit read-back and output checks are placed so that at least one rising edge separates a stimulus from its check. The same-cycle clear case is timed by driving the clear write exactly two edges after the source edge is first sampled.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Software-visible byte offsets
  localparam int OFS_STAT_RD  = 'h00;
  localparam int OFS_STAT_SET = 'h04;
  localparam int OFS_STAT_CLR = 'h08;
  localparam int OFS_MASK_RD  = 'h0C;
  localparam int OFS_MASK_SET = 'h10;
  localparam int OFS_MASK_CLR = 'h14;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic statSet;
    logic statClr;
    logic maskSet;
    logic maskClr;
  } regStrobe_t;

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int ADDR_W  = 8
) (
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [NUM_SRC-1:0] statusQ,
  input  logic [NUM_SRC-1:0] maskQ,
  output regStrobe_t        strobe,
  output logic [NUM_SRC-1:0] busRdData
);

  localparam logic [ADDR_W-1:0] A_STAT_RD  = ADDR_W'(OFS_STAT_RD);
  localparam logic [ADDR_W-1:0] A_STAT_SET = ADDR_W'(OFS_STAT_SET);
  localparam logic [ADDR_W-1:0] A_STAT_CLR = ADDR_W'(OFS_STAT_CLR);
  localparam logic [ADDR_W-1:0] A_MASK_RD  = ADDR_W'(OFS_MASK_RD);
  localparam logic [ADDR_W-1:0] A_MASK_SET = ADDR_W'(OFS_MASK_SET);
  localparam logic [ADDR_W-1:0] A_MASK_CLR = ADDR_W'(OFS_MASK_CLR);

  // Write decode: read-only views and unmapped offsets give no strobe
  always_comb begin
    strobe = '0;
    if (busWe) begin
      case (busAddr)
        A_STAT_SET: strobe.statSet = 1'b1;
        A_STAT_CLR: strobe.statClr = 1'b1;
        A_MASK_SET: strobe.maskSet = 1'b1;
        A_MASK_CLR: strobe.maskClr = 1'b1;
        default:    strobe = '0;
      endcase
    end
  end

  // Read mux: only the two views return data
  always_comb begin
    case (busAddr)
      A_STAT_RD: busRdData = statusQ;
      A_MASK_RD: busRdData = maskQ;
      default:   busRdData = '0;
    endcase
  end

endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC      = 32,
  parameter int SYNC_STAGES  = 2,
  parameter bit KEEP_ON_WARM = 1'b1,
  parameter bit HAS_WAKE     = 1'b1
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               warmRstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  regStrobe_t         strobe,
  input  logic [NUM_SRC-1:0] wrData,
  input  logic               sleepMode,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic               irqOut,
  output logic               wakeOut
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [NUM_SRC-1:0] syncQ [SYNC_STAGES];
  logic [NUM_SRC-1:0] edgeQ;
  logic [NUM_SRC-1:0] riseEv;
  logic [NUM_SRC-1:0] setBits, clrBits, mSetBits, mClrBits;
  logic               pendAny;

  // Synchronizer chain; only power-on reset touches it, so that a warm
  // reset cannot create a false edge on a line that is already high
  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!porRstN) syncQ[g] <= '0;
        else          syncQ[g] <= srcIn;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!porRstN) syncQ[g] <= '0;
        else          syncQ[g] <= syncQ[g-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!porRstN) edgeQ <= '0;
    else          edgeQ <= syncQ[LAST];
  end

  assign riseEv   = syncQ[LAST] & ~edgeQ;
  assign setBits  = strobe.statSet ? wrData : '0;
  assign clrBits  = strobe.statClr ? wrData : '0;
  assign mSetBits = strobe.maskSet ? wrData : '0;
  assign mClrBits = strobe.maskClr ? wrData : '0;

  // Pending vector: a new edge wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!porRstN) begin
      statusQ <= '0;
    end else if (!warmRstN) begin
      if (!KEEP_ON_WARM) statusQ <= '0;
    end else begin
      statusQ <= (statusQ & ~clrBits) | setBits | riseEv;
    end
  end

  // Disable vector: one means disabled
  always_ff @(posedge clk) begin
    if (!porRstN || !warmRstN) maskQ <= '1;
    else                       maskQ <= (maskQ | mSetBits) & ~mClrBits;
  end

  assign pendAny = |(statusQ & ~maskQ);

  always_ff @(posedge clk) begin
    if (!porRstN || !warmRstN) irqOut <= 1'b0;
    else                       irqOut <= pendAny;
  end

  if (HAS_WAKE) begin : g_wake
    always_ff @(posedge clk) begin
      if (!porRstN || !warmRstN) wakeOut <= 1'b0;
      else                       wakeOut <= sleepMode & pendAny;
    end
  end else begin : g_nowake
    assign wakeOut = 1'b0;
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC      = 32,
  parameter int ADDR_W       = 8,
  parameter int SYNC_STAGES  = 2,
  parameter bit KEEP_ON_WARM = 1'b1,
  parameter bit HAS_WAKE     = 1'b1
) (
  input  logic               clk,
  input  logic               porRstN,
  input  logic               warmRstN,
  input  logic [NUM_SRC-1:0] srcIn,
  input  logic               busWe,
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic [NUM_SRC-1:0] busWrData,
  output logic [NUM_SRC-1:0] busRdData,
  input  logic               sleepMode,
  output logic               irqOut,
  output logic               wakeOut
);

  regStrobe_t         strobe;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] maskQ;

  irq_agg_ctrl #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_ctrl (
    .busWe    (busWe),
    .busAddr  (busAddr),
    .statusQ  (statusQ),
    .maskQ    (maskQ),
    .strobe   (strobe),
    .busRdData(busRdData)
  );

  irq_agg_dp #(
    .NUM_SRC     (NUM_SRC),
    .SYNC_STAGES (SYNC_STAGES),
    .KEEP_ON_WARM(KEEP_ON_WARM),
    .HAS_WAKE    (HAS_WAKE)
  ) u_dp (
    .clk      (clk),
    .porRstN  (porRstN),
    .warmRstN (warmRstN),
    .srcIn    (srcIn),
    .strobe   (strobe),
    .wrData   (busWrData),
    .sleepMode(sleepMode),
    .statusQ  (statusQ),
    .maskQ    (maskQ),
    .irqOut   (irqOut),
    .wakeOut  (wakeOut)
  );

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC      = 32,
  parameter int ADDR_W       = 8,
  parameter bit KEEP_ON_WARM = 1'b1
) (
  input logic               clk,
  input logic               porRstN,
  input logic               warmRstN,
  input logic               busWe,
  input logic [ADDR_W-1:0]  busAddr,
  input logic [NUM_SRC-1:0] busWrData,
  input logic               sleepMode,
  input logic [NUM_SRC-1:0] statusQ,
  input logic [NUM_SRC-1:0] maskQ,
  input logic               irqOut,
  input logic               wakeOut
);

  logic               wrStatSet, wrStatClr, wrMaskSet, wrMaskClr;
  logic [NUM_SRC-1:0] clrMask;

  assign wrStatSet = busWe && (busAddr == ADDR_W'(OFS_STAT_SET));
  assign wrStatClr = busWe && (busAddr == ADDR_W'(OFS_STAT_CLR));
  assign wrMaskSet = busWe && (busAddr == ADDR_W'(OFS_MASK_SET));
  assign wrMaskClr = busWe && (busAddr == ADDR_W'(OFS_MASK_CLR));
  assign clrMask   = wrStatClr ? busWrData : '0;

  // R5
  mask_set_chk: assert property (@(posedge clk) disable iff (!porRstN)
    wrMaskSet |=> ((maskQ & $past(busWrData)) == $past(busWrData)));

  // R5
  mask_clr_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (wrMaskClr && warmRstN) |=> ((maskQ & $past(busWrData)) == '0));

  // R4
  stat_set_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (wrStatSet && warmRstN) |=> ((statusQ & $past(busWrData)) == $past(busWrData)));

  // R3
  sticky_pend_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (($past(statusQ) & ~statusQ & ~$past(clrMask)) == '0));

  // R8
  warm_mask_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !warmRstN |=> (maskQ == '1 && !irqOut && !wakeOut));

  // R8
  warm_keep_chk: assert property (@(posedge clk) disable iff (!porRstN)
    (!warmRstN && KEEP_ON_WARM) |=> (statusQ == $past(statusQ)));

  // R9
  wake_gate_chk: assert property (@(posedge clk) disable iff (!porRstN)
    !sleepMode |=> !wakeOut);

  // R6
  irq_cause_chk: assert property (@(posedge clk) disable iff (!porRstN)
    $rose(irqOut) |-> $past(|(statusQ & ~maskQ)));

endmodule

bind irq_aggregator irq_agg_chk #(
  .NUM_SRC     (NUM_SRC),
  .ADDR_W      (ADDR_W),
  .KEEP_ON_WARM(KEEP_ON_WARM)
) u_chk (
  .clk      (clk),
  .porRstN  (porRstN),
  .warmRstN (warmRstN),
  .busWe    (busWe),
  .busAddr  (busAddr),
  .busWrData(busWrData),
  .sleepMode(sleepMode),
  .statusQ  (statusQ),
  .maskQ    (maskQ),
  .irqOut   (irqOut),
  .wakeOut  (wakeOut)
);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        warmRstN = 1'b0;
  logic [31:0] srcIn = '0;
  logic        busWe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        sleepMode = 1'b0;
  logic        irqOut, wakeOut;

  int cmpCnt = 0;
  int errCnt = 0;
  bit done = 1'b0;
  bit armed = 1'b0;

  // Reference model state
  logic [31:0] mStat, mMask;
  logic        mIrq, mWake;
  logic [31:0] hist [$];
  logic [31:0] rise, h2, h3;
  logic        anyPend;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .porRstN(porRstN), .warmRstN(warmRstN), .srcIn(srcIn),
    .busWe(busWe), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .sleepMode(sleepMode),
    .irqOut(irqOut), .wakeOut(wakeOut)
  );

  // Model: hist holds the input samples of previous edges, newest first
  always @(posedge clk) begin
    if (!porRstN) begin
      mStat = '0; mMask = '1; mIrq = 1'b0; mWake = 1'b0;
      hist = '{32'h0, 32'h0, 32'h0};
    end else begin
      h2 = hist[1];
      h3 = hist[2];
      rise = h2 & ~h3;
      if (!warmRstN) begin
        mMask = '1; mIrq = 1'b0; mWake = 1'b0;
      end else begin
        anyPend = |(mStat & ~mMask);
        mIrq = anyPend;
        mWake = sleepMode & anyPend;
        if (busWe && busAddr == 8'h08) mStat = mStat & ~busWrData;
        if (busWe && busAddr == 8'h04) mStat = mStat | busWrData;
        mStat = mStat | rise;
        if (busWe && busAddr == 8'h10) mMask = mMask | busWrData;
        if (busWe && busAddr == 8'h14) mMask = mMask & ~busWrData;
      end
      hist.push_front(srcIn);
      void'(hist.pop_back());
    end
    armed = 1'b1;
  end

  // Cycle-by-cycle comparison of both outputs
  always @(negedge clk) begin
    if (armed && !done) begin
      cmpCnt++;
      if (irqOut !== mIrq) begin
        errCnt++;
        $display("FAIL R6 irqOut per-cycle: got %b expected %b at %0t", irqOut, mIrq, $time);
      end
      cmpCnt++;
      if (wakeOut !== mWake) begin
        errCnt++;
        $display("FAIL R9 wakeOut per-cycle: got %b expected %b at %0t", wakeOut, mWake, $time);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWe = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWe = 1'b0; busWrData = '0;
  endtask

  task automatic chkConst(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busAddr = a;
    #1;
    cmpCnt++;
    if (busRdData !== exp) begin
      errCnt++;
      $display("FAIL %s read %h: got %h expected %h", tag, a, busRdData, exp);
    end
    cmpCnt++;
    if (a == 8'h00 && busRdData !== mStat) begin
      errCnt++;
      $display("FAIL %s pending vs model: got %h expected %h", tag, busRdData, mStat);
    end
  endtask

  task automatic chkIrq(input logic exp, input string tag);
    @(negedge clk);
    #1;
    cmpCnt++;
    if (irqOut !== exp) begin
      errCnt++;
      $display("FAIL %s irqOut: got %b expected %b", tag, irqOut, exp);
    end
  endtask

  task automatic chkWake(input logic exp, input string tag);
    @(negedge clk);
    #1;
    cmpCnt++;
    if (wakeOut !== exp) begin
      errCnt++;
      $display("FAIL %s wakeOut: got %b expected %b", tag, wakeOut, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      errCnt++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, errCnt);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    porRstN = 1'b1; warmRstN = 1'b1;

    // R1 reset state
    chkConst(8'h00, 32'h0, "R1");
    chkConst(8'h0C, 32'hFFFF_FFFF, "R1");
    chkIrq(1'b0, "R1");

    // R5 enable all
    wr(8'h14, 32'hFFFF_FFFF);
    chkConst(8'h0C, 32'h0, "R5");

    // R2 single-cycle pulse, sticky after input falls
    step(); srcIn = 32'h8;
    step(); srcIn = 32'h0;
    repeat (4) step();
    chkConst(8'h00, 32'h8, "R2");
    chkIrq(1'b1, "R6");

    // R3 zero write, then acknowledge
    wr(8'h08, 32'h0);
    chkConst(8'h00, 32'h8, "R3");
    wr(8'h08, 32'h8);
    chkIrq(1'b0, "R6");
    chkConst(8'h00, 32'h0, "R3");

    // R4 software set, R5 disable/enable
    wr(8'h04, 32'h8000_0001);
    chkConst(8'h00, 32'h8000_0001, "R4");
    wr(8'h10, 32'h1);
    chkConst(8'h0C, 32'h1, "R5");
    chkIrq(1'b1, "R6");
    wr(8'h10, 32'h8000_0000);
    chkIrq(1'b0, "R6");
    wr(8'h14, 32'h0);
    chkConst(8'h0C, 32'h8000_0001, "R5");
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    chkConst(8'h00, 32'h0, "R3");

    // R7 edge arrives at the same edge as the clear write
    wr(8'h04, 32'h20);
    step(); srcIn = 32'h20;
    step();
    wr(8'h08, 32'h20);
    chkConst(8'h00, 32'h20, "R7");

    // R11 input held high, cleared bit stays clear
    wr(8'h08, 32'h20);
    repeat (4) step();
    chkConst(8'h00, 32'h0, "R11");
    srcIn = 32'h0;

    // R10 read-only views and unmapped reads
    wr(8'h00, 32'h0000_FFFF);
    wr(8'h0C, 32'h0000_FFFF);
    chkConst(8'h00, 32'h0, "R10");
    chkConst(8'h0C, 32'h0, "R10");
    chkConst(8'h18, 32'h0, "R10");
    chkConst(8'h3C, 32'h0, "R10");
    chkConst(8'h04, 32'h0, "R10");

    // R9 wake gating
    sleepMode = 1'b0;
    wr(8'h04, 32'h4);
    chkWake(1'b0, "R9");
    step(); sleepMode = 1'b1;
    chkWake(1'b1, "R9");
    wr(8'h10, 32'h4);
    chkWake(1'b0, "R9");
    step(); sleepMode = 1'b0;
    wr(8'h14, 32'hFFFF_FFFF);

    // R8 warm reset keeps pending bits
    wr(8'h04, 32'hF0);
    chkIrq(1'b1, "R8");
    step(); warmRstN = 1'b0;
    chkIrq(1'b0, "R8");
    chkConst(8'h0C, 32'hFFFF_FFFF, "R8");
    chkConst(8'h00, 32'hF4, "R8");
    step(); warmRstN = 1'b1;
    chkIrq(1'b0, "R8");
    chkConst(8'h00, 32'hF4, "R8");

    // R1 power-on reset clears pending
    step(); porRstN = 1'b0;
    step(); step(); porRstN = 1'b1;
    chkConst(8'h00, 32'h0, "R1");
    chkConst(8'h0C, 32'hFFFF_FFFF, "R1");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", cmpCnt, errCnt);
    $finish;
  end

endmodule